// File: doc/BRIEF.md
# Indirect-Addressed I/O Register Window

This block is the 32-byte I/O slave window of a network controller. An 8-bit pointer register chooses one of eight control registers and one of eight bus-configuration registers. Software then reaches the chosen register through one of two data ports. The window also holds a 16-byte station-address PROM, which can be written only while an enable bit in the bus-configuration set is high. Reading a dedicated reset port fires a soft reset. That reset clears the control registers and the pointer, but it leaves the bus-configuration registers, the PROM and the access-mode flag alone. While the soft reset runs, every access is refused with a retry termination.

After a hardware reset the window works in 16-bit word mode. The first 32-bit write to the control data port at offset 10h switches it to 32-bit mode. From then on only a hardware reset brings it back to word mode. Each mode has its own layout of the window. Accesses that do not fit the current layout read zero and are discarded on write.

A five-state sequencer handles every access. ST_IDLE and ST_ACK accept a request. An accepted request is answered in the next cycle: ST_ACK answers a normal access, and ST_ACK_SRST answers a reset-port read while driving the soft-reset pulse. ST_ACK_SRST always moves on to a busy state. That busy state is ST_RETRY when a request is waiting, which is answered with a retry, or ST_RESET when no request is waiting. The busy states count down SRST_CYCLES-1 cycles. Once the count reaches zero, a waiting request is accepted, going to ST_ACK or ST_ACK_SRST. With no waiting request the sequencer returns to ST_IDLE.

Top module: `io_reg_window`

## Requirements
- R1: After a hardware reset, dword_mode is 0, devsel, trdy and stop are low, and the pointer and all control registers read 0.
- R2: In word mode, all at word size (req_size=1): the pointer is at 12h (data bits 7:0), the control data port is at 10h and the bus-configuration data port is at 16h. The data ports reach register pointer[2:0] and keep 16 bits each. A request accepted at a clock edge is answered during the following cycle with devsel=1, trdy=1, stop=0 and the read data on rdata.
- R3: The PROM occupies 00h-0Fh. In word mode it can be read in bytes (req_size=0) at any offset, or in words at even offsets. Byte offset+k is returned on data lanes 8k+7:8k, with unused upper lanes zero.
- R4: PROM writes (word size in word mode, dword size in dword mode) take effect only while bus-configuration register 2 bit 8 is 1. Otherwise they leave the PROM unchanged.
- R5: In word mode a dword-size write (req_size=2) to 10h writes the control register and sets dword_mode. The mode flag reads back as bit 7 of bus-configuration register 3, and that bit ignores writes.
- R6: In dword mode every access is dword-size and 4-aligned. The PROM is at 00h-0Fh, the control data port at 10h, the pointer at 14h, the reset port at 18h and the bus-configuration data port at 1Ch.
- R7: Any access at an offset or size that the current mode does not allow reads 0, and a write of that kind changes nothing. Examples: an odd word address, reserved space, a byte write, or a word access in dword mode.
- R8: Reading the reset port returns 0 and raises soft_reset during that response cycle. After that cycle the control registers and the pointer are 0. The bus-configuration registers, the PROM and dword_mode are kept. A write to the reset port does nothing.
- R9: For SRST_CYCLES cycles, starting with the soft_reset cycle, any request is answered with devsel=1, stop=1, trdy=0 and has no effect. The first request after that window is accepted normally. trdy and stop are never high together.
- R10: When the pointer is 8 or more, both data ports read 0 and writes through them are discarded.
- R11: Only a hardware reset clears dword_mode once it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| req_valid | input | 1 | One-cycle access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset within the window |
| req_size | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| req_wdata | input | 32 | Write data, low lanes first |
| rdata | output | 32 | Read data, valid while trdy is high |
| devsel | output | 1 | Device selected (response cycle) |
| trdy | output | 1 | Target ready: access completed |
| stop | output | 1 | Retry: access refused |
| soft_reset | output | 1 | Soft-reset pulse |
| dword_mode | output | 1 | 32-bit access mode flag |

## Verification
The hardest point to reach is the exact edge of the retry window. A request arriving in the last busy cycle must still be refused, and the request in the very next cycle must be accepted normally. No idle cycle may be lost or added between them. The bench reaches this point by reading the reset port and then issuing a back-to-back stream of writes to the pointer. It expects exactly SRST_CYCLES retries, then one normal completion, and it confirms that every refused write left the pointer at zero. The same soft reset is repeated after the switch to dword mode, to show that the mode flag survives it and that only a hardware reset clears it.

// File: rtl/iow_pkg.sv
package iow_pkg;

    localparam int WIN_AW    = 5;
    localparam int DATA_W    = 32;
    localparam int LANES     = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        TG_NONE,
        TG_PROM,
        TG_CSR,
        TG_PTR,
        TG_RST,
        TG_BCR
    } target_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_ACK_SRST,
        ST_RESET,
        ST_RETRY
    } seq_state_e;

    // window layout
    localparam logic [WIN_AW-1:0] PROM_SPAN = 5'h10;
    localparam logic [WIN_AW-1:0] W_CSR     = 5'h10;
    localparam logic [WIN_AW-1:0] W_PTR     = 5'h12;
    localparam logic [WIN_AW-1:0] W_RST     = 5'h14;
    localparam logic [WIN_AW-1:0] W_BCR     = 5'h16;
    localparam logic [WIN_AW-1:0] D_CSR     = 5'h10;
    localparam logic [WIN_AW-1:0] D_PTR     = 5'h14;
    localparam logic [WIN_AW-1:0] D_RST     = 5'h18;
    localparam logic [WIN_AW-1:0] D_BCR     = 5'h1C;

    // bus-configuration bit positions
    localparam int BCR_PROM_IDX = 2;
    localparam int BCR_PROM_BIT = 8;
    localparam int BCR_MODE_IDX = 3;
    localparam int BCR_MODE_BIT = 7;

    function automatic logic [2:0] size_bytes(input acc_size_e sz);
        unique case (sz)
            SZ_BYTE:  size_bytes = 3'd1;
            SZ_WORD:  size_bytes = 3'd2;
            SZ_DWORD: size_bytes = 3'd4;
            default:  size_bytes = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/iow_decode.sv
module iow_decode
    import iow_pkg::*;
(
    input  logic              dword_mode,
    input  logic [WIN_AW-1:0] addr,
    input  logic [1:0]        size,
    input  logic              write,
    output target_e           target,
    output logic              set_dword
);

    acc_size_e sz;
    assign sz = acc_size_e'(size);

    always_comb begin
        target    = TG_NONE;
        set_dword = 1'b0;
        if (!dword_mode) begin
            if (addr < PROM_SPAN) begin
                if (sz == SZ_BYTE && !write)
                    target = TG_PROM;
                else if (sz == SZ_WORD && !addr[0])
                    target = TG_PROM;
            end else if (sz == SZ_WORD) begin
                case (addr)
                    W_CSR:   target = TG_CSR;
                    W_PTR:   target = TG_PTR;
                    W_RST:   target = TG_RST;
                    W_BCR:   target = TG_BCR;
                    default: target = TG_NONE;
                endcase
            end else if (sz == SZ_DWORD && write && addr == W_CSR) begin
                target    = TG_CSR;
                set_dword = 1'b1;
            end
        end else if (sz == SZ_DWORD && addr[1:0] == 2'b00) begin
            if (addr < PROM_SPAN) begin
                target = TG_PROM;
            end else begin
                case (addr)
                    D_CSR:   target = TG_CSR;
                    D_PTR:   target = TG_PTR;
                    D_RST:   target = TG_RST;
                    D_BCR:   target = TG_BCR;
                    default: target = TG_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/iow_regs.sv
module iow_regs
    import iow_pkg::*;
#(
    parameter int NREG       = 8,
    parameter int REG_W      = 16,
    parameter int PTR_W      = 8,
    parameter int PROM_BYTES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  srst,
    input  logic                  wr_en,
    input  target_e               target,
    input  logic [1:0]            size,
    input  logic [$clog2(PROM_BYTES)-1:0] byte_off,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  set_dword,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  dword_mode
);

    localparam int IDX_W  = $clog2(NREG);
    localparam int PROM_AW = $clog2(PROM_BYTES);
    localparam logic [PTR_W-1:0] NREG_P = PTR_W'(NREG);
    localparam logic [IDX_W-1:0] MODE_IDX = IDX_W'(BCR_MODE_IDX);

    logic [REG_W-1:0]        csr_q [NREG];
    logic [REG_W-1:0]        bcr_q [NREG];
    logic [PTR_W-1:0]        ptr_q;
    logic                    mode_q;
    logic [PROM_BYTES*8-1:0] prom_q;

    logic             ptr_hit;
    logic [IDX_W-1:0] idx;
    logic             prom_wen;
    logic [2:0]       nbytes;
    logic [REG_W-1:0] bcr_view;

    assign ptr_hit    = ptr_q < NREG_P;
    assign idx        = ptr_q[IDX_W-1:0];
    assign prom_wen   = bcr_q[BCR_PROM_IDX][BCR_PROM_BIT];
    assign nbytes     = size_bytes(acc_size_e'(size));
    assign dword_mode = mode_q;

    always_comb begin
        bcr_view = bcr_q[idx];
        if (idx == MODE_IDX)
            bcr_view[BCR_MODE_BIT] = mode_q;
    end

    always_comb begin
        rd_data = '0;
        case (target)
            TG_PROM: begin
                for (int k = 0; k < LANES; k++) begin
                    if (k < int'(nbytes))
                        rd_data[8*k +: 8] =
                            prom_q[{byte_off + PROM_AW'(k), 3'b000} +: 8];
                end
            end
            TG_CSR:  if (ptr_hit) rd_data[REG_W-1:0] = csr_q[idx];
            TG_PTR:  rd_data[PTR_W-1:0] = ptr_q;
            TG_BCR:  if (ptr_hit) rd_data[REG_W-1:0] = bcr_view;
            default: rd_data = '0;
        endcase
    end

    // soft-reset domain: control registers and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int i = 0; i < NREG; i++) csr_q[i] <= '0;
        end else if (srst) begin
            ptr_q <= '0;
            for (int i = 0; i < NREG; i++) csr_q[i] <= '0;
        end else if (wr_en) begin
            if (target == TG_PTR)
                ptr_q <= wdata[PTR_W-1:0];
            if (target == TG_CSR && ptr_hit)
                csr_q[idx] <= wdata[REG_W-1:0];
        end
    end

    // hardware-reset domain: bus configuration, PROM, mode flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prom_q <= '0;
            mode_q <= 1'b0;
            for (int i = 0; i < NREG; i++) bcr_q[i] <= '0;
        end else if (wr_en) begin
            if (set_dword)
                mode_q <= 1'b1;
            if (target == TG_BCR && ptr_hit)
                bcr_q[idx] <= wdata[REG_W-1:0];
            if (target == TG_PROM && prom_wen) begin
                for (int k = 0; k < LANES; k++) begin
                    if (k < int'(nbytes))
                        prom_q[{byte_off + PROM_AW'(k), 3'b000} +: 8] <= wdata[8*k +: 8];
                end
            end
        end
    end

    // R11: mode flag is sticky until hardware reset
    p_mode_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |=> mode_q);

    // R8: pointer is zero after the soft-reset pulse
    p_srst_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (ptr_q == '0));

    // R4: PROM stays put while writes are disabled
    p_prom_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !prom_wen |=> $stable(prom_q));

endmodule

// File: rtl/iow_seq.sv
module iow_seq
    import iow_pkg::*;
#(
    parameter int SRST_CYCLES = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic is_rst_read,
    output logic accept,
    output logic srst_pulse,
    output logic devsel,
    output logic trdy,
    output logic stop
);

    localparam int CNT_W = $clog2(SRST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SRST_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             busy;

    assign busy   = (state_q == ST_RESET) || (state_q == ST_RETRY);
    assign accept = req_valid &&
                    ((state_q == ST_IDLE) || (state_q == ST_ACK) ||
                     (busy && cnt_q == '0));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_ACK: begin
                if (req_valid) state_d = is_rst_read ? ST_ACK_SRST : ST_ACK;
                else           state_d = ST_IDLE;
            end
            ST_ACK_SRST: state_d = req_valid ? ST_RETRY : ST_RESET;
            ST_RESET, ST_RETRY: begin
                if (cnt_q == '0) begin
                    if (req_valid) state_d = is_rst_read ? ST_ACK_SRST : ST_ACK;
                    else           state_d = ST_IDLE;
                end else begin
                    state_d = req_valid ? ST_RETRY : ST_RESET;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ACK_SRST)
                cnt_q <= CNT_LOAD;
            else if (busy && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        devsel     = 1'b0;
        trdy       = 1'b0;
        stop       = 1'b0;
        srst_pulse = 1'b0;
        unique case (state_q)
            ST_ACK:      begin devsel = 1'b1; trdy = 1'b1; end
            ST_ACK_SRST: begin devsel = 1'b1; trdy = 1'b1; srst_pulse = 1'b1; end
            ST_RETRY:    begin devsel = 1'b1; stop = 1'b1; end
            default:     ;
        endcase
    end

    // R2: accepted request completes in the next cycle
    p_accept_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (devsel && trdy && !stop));

    // R9: refused request gets a retry termination
    p_refuse_retry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !accept) |=> (devsel && stop && !trdy));

    // R9: completion and retry are exclusive
    p_trdy_stop_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(trdy && stop));

    // R8: soft-reset pulse is followed by the busy window
    p_pulse_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        srst_pulse |=> busy);

endmodule

// File: rtl/io_reg_window.sv
module io_reg_window
    import iow_pkg::*;
#(
    parameter int SRST_CYCLES = 250,
    parameter int NREG        = 8,
    parameter int REG_W       = 16,
    parameter int PTR_W       = 8,
    parameter int PROM_BYTES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [4:0]        req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rdata,
    output logic              devsel,
    output logic              trdy,
    output logic              stop,
    output logic              soft_reset,
    output logic              dword_mode
);

    localparam int PROM_AW = $clog2(PROM_BYTES);

    target_e            target;
    logic               set_dword;
    logic               accept;
    logic               srst_pulse;
    logic [DATA_W-1:0]  rd_data;
    logic [DATA_W-1:0]  rdata_q;
    logic               is_rst_read;

    assign is_rst_read = (target == TG_RST) && !req_write;

    iow_decode u_decode (
        .dword_mode (dword_mode),
        .addr       (req_addr),
        .size       (req_size),
        .write      (req_write),
        .target     (target),
        .set_dword  (set_dword)
    );

    iow_regs #(
        .NREG       (NREG),
        .REG_W      (REG_W),
        .PTR_W      (PTR_W),
        .PROM_BYTES (PROM_BYTES)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst       (srst_pulse),
        .wr_en      (accept && req_write),
        .target     (target),
        .size       (req_size),
        .byte_off   (req_addr[PROM_AW-1:0]),
        .wdata      (req_wdata),
        .set_dword  (set_dword),
        .rd_data    (rd_data),
        .dword_mode (dword_mode)
    );

    iow_seq #(
        .SRST_CYCLES (SRST_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .is_rst_read (is_rst_read),
        .accept      (accept),
        .srst_pulse  (srst_pulse),
        .devsel      (devsel),
        .trdy        (trdy),
        .stop        (stop)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (accept)
            rdata_q <= req_write ? '0 : rd_data;
    end

    assign rdata      = rdata_q;
    assign soft_reset = srst_pulse;

endmodule

// File: tb/io_reg_window_test.sv
`timescale 1ns/1ps
module io_reg_window_test;

    localparam int SRST = 250;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rdata;
    logic        devsel, trdy, stop, soft_reset, dword_mode;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] r_data;
    logic        r_dev, r_trdy, r_stop, r_srst;

    always #2 clk = ~clk;

    io_reg_window #(.SRST_CYCLES(SRST)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rdata(rdata), .devsel(devsel), .trdy(trdy), .stop(stop),
        .soft_reset(soft_reset), .dword_mode(dword_mode)
    );

    task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [4:0] a, input logic [1:0] sz,
                       input logic [31:0] d);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        r_data = rdata; r_dev = devsel; r_trdy = trdy; r_stop = stop; r_srst = soft_reset;
        req_valid = 1'b0;
    endtask

    task automatic hw_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 dword_mode", {31'd0, dword_mode}, 32'd0);
        check("R1 idle termination", {29'd0, devsel, trdy, stop}, 32'd0);
        acc(0, 5'h12, 2'd1, 0);
        check("R1 pointer", r_data, 32'd0);
        acc(0, 5'h10, 2'd1, 0);
        check("R1 csr0", r_data, 32'd0);
    endtask

    task automatic t_word_map();
        acc(1, 5'h12, 2'd1, 32'h2);
        acc(0, 5'h12, 2'd1, 0);
        check("R2 pointer readback", r_data, 32'h2);
        check("R2 completion", {29'd0, r_dev, r_trdy, r_stop}, 32'b110);
        acc(1, 5'h12, 2'd1, 32'h1);
        acc(1, 5'h10, 2'd1, 32'hFFFF_A5A5);
        acc(0, 5'h10, 2'd1, 0);
        check("R2 csr1", r_data, 32'hA5A5);
        acc(1, 5'h12, 2'd1, 32'h5);
        acc(1, 5'h16, 2'd1, 32'h1234);
        acc(0, 5'h16, 2'd1, 0);
        check("R2 bcr5", r_data, 32'h1234);
        acc(1, 5'h12, 2'd1, 32'h3);
        acc(1, 5'h16, 2'd1, 32'h00FF);
        acc(0, 5'h16, 2'd1, 0);
        check("R5 bcr3 mode bit clear in word mode", r_data, 32'h007F);
    endtask

    task automatic t_prom();
        acc(1, 5'h12, 2'd1, 32'h2);
        acc(1, 5'h16, 2'd1, 32'h0100);
        acc(1, 5'h00, 2'd1, 32'h2211);
        acc(1, 5'h02, 2'd1, 32'h4433);
        acc(0, 5'h01, 2'd0, 0);
        check("R3 byte read 01h", r_data, 32'h22);
        acc(0, 5'h03, 2'd0, 0);
        check("R3 byte read 03h", r_data, 32'h44);
        acc(0, 5'h02, 2'd1, 0);
        check("R3 word read 02h", r_data, 32'h4433);
        acc(1, 5'h16, 2'd1, 32'h0000);
        acc(1, 5'h00, 2'd1, 32'hFFFF);
        acc(0, 5'h00, 2'd1, 0);
        check("R4 prom write blocked", r_data, 32'h2211);
    endtask

    task automatic t_illegal();
        acc(0, 5'h11, 2'd1, 0);
        check("R7 odd word read", r_data, 32'd0);
        acc(0, 5'h10, 2'd2, 0);
        check("R7 dword read in word mode", r_data, 32'd0);
        acc(0, 5'h18, 2'd1, 0);
        check("R7 reserved read", r_data, 32'd0);
        acc(1, 5'h13, 2'd1, 32'h7);
        acc(0, 5'h12, 2'd1, 0);
        check("R7 odd write left pointer", r_data, 32'h2);
        acc(1, 5'h16, 2'd1, 32'h0100);
        acc(1, 5'h00, 2'd0, 32'hEE);
        acc(0, 5'h00, 2'd0, 0);
        check("R7 byte write discarded", r_data, 32'h11);
        acc(1, 5'h16, 2'd1, 32'h0000);
    endtask

    task automatic t_ptr_range();
        acc(1, 5'h12, 2'd1, 32'h9);
        acc(1, 5'h10, 2'd1, 32'h5555);
        acc(0, 5'h10, 2'd1, 0);
        check("R10 csr read out of range", r_data, 32'd0);
        acc(0, 5'h16, 2'd1, 0);
        check("R10 bcr read out of range", r_data, 32'd0);
        acc(1, 5'h12, 2'd1, 32'h1);
        acc(0, 5'h10, 2'd1, 0);
        check("R10 csr1 untouched", r_data, 32'hA5A5);
    endtask

    task automatic t_soft_reset_word();
        int retries;
        acc(0, 5'h14, 2'd1, 0);
        check("R8 reset port read data", r_data, 32'd0);
        check("R8 soft_reset with completion", {30'd0, r_srst, r_trdy}, 32'b11);
        retries = 0;
        for (int i = 0; i < SRST; i++) begin
            acc(1, 5'h12, 2'd1, 32'h7);
            if (r_dev && r_stop && !r_trdy) retries++;
        end
        check("R9 retry count", retries, SRST);
        acc(0, 5'h12, 2'd1, 0);
        check("R9 first access after window", {29'd0, r_dev, r_trdy, r_stop}, 32'b110);
        check("R8 R9 pointer cleared, retried write dropped", r_data, 32'd0);
        acc(1, 5'h12, 2'd1, 32'h1);
        acc(0, 5'h10, 2'd1, 0);
        check("R8 csr1 cleared", r_data, 32'd0);
        acc(1, 5'h12, 2'd1, 32'h5);
        acc(0, 5'h16, 2'd1, 0);
        check("R8 bcr5 kept", r_data, 32'h1234);
        acc(0, 5'h00, 2'd1, 0);
        check("R8 prom kept", r_data, 32'h2211);
        acc(1, 5'h12, 2'd1, 32'h1);
        acc(1, 5'h10, 2'd1, 32'h7777);
        acc(1, 5'h14, 2'd1, 32'hFFFF);
        check("R8 reset port write no pulse", {31'd0, r_srst}, 32'd0);
        acc(0, 5'h10, 2'd1, 0);
        check("R8 reset port write no effect", {r_data[15:0], 13'd0, r_dev, r_trdy, r_stop},
              {16'h7777, 16'b110});
    endtask

    task automatic t_dword();
        acc(1, 5'h10, 2'd2, 32'h0000_00AB);
        check("R5 dword_mode set", {31'd0, dword_mode}, 32'd1);
        acc(0, 5'h12, 2'd1, 0);
        check("R7 word read in dword mode", r_data, 32'd0);
        acc(0, 5'h14, 2'd2, 0);
        check("R6 pointer at 14h", r_data, 32'h1);
        acc(0, 5'h10, 2'd2, 0);
        check("R5 R6 csr1 via dword write", r_data, 32'hAB);
        acc(1, 5'h14, 2'd2, 32'h3);
        acc(0, 5'h1C, 2'd2, 0);
        check("R5 mode bit in bcr3", r_data, 32'h00FF);
        acc(0, 5'h00, 2'd2, 0);
        check("R6 prom dword read", r_data, 32'h4433_2211);
        acc(1, 5'h14, 2'd2, 32'h2);
        acc(1, 5'h1C, 2'd2, 32'h0100);
        acc(1, 5'h04, 2'd2, 32'hDDCC_BBAA);
        acc(0, 5'h04, 2'd2, 0);
        check("R4 R6 prom dword write enabled", r_data, 32'hDDCC_BBAA);
        acc(1, 5'h14, 2'd1, 32'h6);
        acc(0, 5'h14, 2'd2, 0);
        check("R7 word write in dword mode dropped", r_data, 32'h2);
    endtask

    task automatic t_soft_reset_dword();
        acc(0, 5'h18, 2'd2, 0);
        check("R6 R8 reset port at 18h", {31'd0, r_srst}, 32'd1);
        repeat (SRST + 4) @(negedge clk);
        check("R11 mode kept over soft reset", {31'd0, dword_mode}, 32'd1);
        acc(0, 5'h14, 2'd2, 0);
        check("R8 pointer cleared in dword mode", r_data, 32'd0);
        hw_reset();
        check("R11 hardware reset clears mode", {31'd0, dword_mode}, 32'd0);
        acc(0, 5'h00, 2'd1, 0);
        check("R1 prom cleared by hardware reset", r_data, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_map();
        t_prom();
        t_illegal();
        t_ptr_range();
        t_soft_reset_word();
        t_dword();
        t_soft_reset_dword();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule